// File: doc/BRIEF.md
# Single-Precision Round-to-Nearest-Even Packer

This combinational unit is the last stage of a single-precision multiplier datapath. It takes a result sign, a 48-bit significand whose leading one sits at bit 47, a signed 12-bit unbiased exponent and the 8-bit biased exponent field the upstream stage has already worked out. It rounds the significand to 24 retained bits, ties going to the even value, and packs the rounded value into a 32-bit word.

The low 24 bits of the significand are the guard and sticky region. Rounding adds half a unit in the last place to the whole 48-bit value. A wrap of that 48-bit sum is the carry-out. The unit then shifts the sum right by one, forces the top bit and raises both exponent forms. A subnormal input, signalled by an exponent field of zero, that rounds up into bit 47 leaves as the smallest normal. A signed exponent of +128 or more after rounding gives an infinity with the input sign. NaN and zero operands, and rounding modes other than this one, are handled upstream.

Top module: `rne_pack_unit`

## Requirements
- R1: When the low 24 significand bits equal exactly 0x800000 and bit 24 is 0, the retained bits pass unchanged.
- R2: When the low 24 bits equal exactly 0x800000 and bit 24 is 1, the retained bits are incremented by one.
- R3: Low bits greater than 0x800000 round the retained bits up. Low bits less than 0x800000, including a lone sticky bit, are dropped.
- R4: If adding 0x800000 to the 48-bit significand wraps, the result is the sum shifted right by one with bit 47 set, and both the signed exponent and the exponent field are one higher.
- R5: If the signed exponent after rounding is +128 or greater, the output is infinity: exponent field 0xFF, mantissa 0, input sign kept.
- R6: The exponent compare is signed. Values with bit 11 set (for example 0x800 and 0xFFF) are negative and never overflow, while 0x7FF overflows.
- R7: With an input exponent field of 0, a rounded significand with bit 47 set is emitted with exponent field 0x01. Otherwise the field is passed through, incremented only per R4.
- R8: The output word is {sign at bit 31, exponent field at bits 30..23, significand bits 46..24 at bits 22..0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the result |
| sig_i | input | 48 | Significand, leading one at bit 47, low 24 bits for rounding |
| sexp_i | input | 12 | Signed unbiased exponent, two's complement |
| efld_i | input | 8 | Provisional biased exponent field, 0 for subnormal |
| result_o | output | 32 | Packed single-precision result |

## Verification
Exact ties are applied with an even retained bit and with an odd one. This shows whether the tie is resolved on bit 24 or simply rounded up. Values just above and just below the halfway point, and a lone sticky bit, separate the strict comparisons from off-by-one thresholds. An all-ones retained field with a tie checks the wrap, renormalization and exponent increment. The same field with an exponent of 127 checks overflow after carry. Exponents 0x800, 0xFFF and 0x7FF show whether the compare is signed, and subnormal ties at 0x7FFFFF and 0x7FFFFE show whether promotion happens only when the rounding reaches bit 47.

// File: rtl/rne_pkg.sv
package rne_pkg;

    localparam int SIG_W  = 48;
    localparam int MANT_W = 23;
    localparam int EFLD_W = 8;
    localparam int SEXP_W = 12;

    // position of the low-order rounding region relative to the significand
    localparam int RND_W  = SIG_W - MANT_W - 1;
    localparam int RES_W  = 1 + EFLD_W + MANT_W;

    // where the low rounding bits sit relative to one half ulp
    typedef enum logic [1:0] {
        ZONE_BELOW = 2'd0,
        ZONE_TIE   = 2'd1,
        ZONE_ABOVE = 2'd2
    } rnd_zone_e;

    // rounding decision carried between stages
    typedef enum logic {
        ACT_KEEP = 1'b0,
        ACT_BUMP = 1'b1
    } rnd_act_e;

endpackage

// File: rtl/rne_round_decide.sv
module rne_round_decide
    import rne_pkg::*;
#(
    parameter int SIG_W = rne_pkg::SIG_W,
    parameter int RND_W = rne_pkg::RND_W
) (
    input  logic [SIG_W-1:0] sig_i,
    output rnd_zone_e        zone_o,
    output rnd_act_e         act_o
);
    localparam logic [RND_W-1:0] HALF_ULP = RND_W'(1) << (RND_W - 1);

    logic [RND_W-1:0] low_bits;
    logic             keep_lsb;

    assign low_bits = sig_i[RND_W-1:0];
    assign keep_lsb = sig_i[RND_W];

    always_comb begin
        if (low_bits == HALF_ULP) begin
            zone_o = ZONE_TIE;
        end else if (low_bits > HALF_ULP) begin
            zone_o = ZONE_ABOVE;
        end else begin
            zone_o = ZONE_BELOW;
        end
    end

    always_comb begin
        unique case (zone_o)
            ZONE_TIE:   act_o = keep_lsb ? ACT_BUMP : ACT_KEEP;
            ZONE_ABOVE: act_o = ACT_BUMP;
            default:    act_o = ACT_KEEP;
        endcase
    end

endmodule

// File: rtl/rne_round_apply.sv
module rne_round_apply
    import rne_pkg::*;
#(
    parameter int SIG_W  = rne_pkg::SIG_W,
    parameter int RND_W  = rne_pkg::RND_W,
    parameter int SEXP_W = rne_pkg::SEXP_W,
    parameter int EFLD_W = rne_pkg::EFLD_W
) (
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [SEXP_W-1:0] sexp_i,
    input  logic [EFLD_W-1:0] efld_i,
    input  rnd_act_e          act_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic [SEXP_W-1:0] sexp_o,
    output logic [EFLD_W-1:0] efld_o,
    output logic              carry_o
);
    localparam logic [SIG_W-1:0] HALF_ULP = SIG_W'(1) << (RND_W - 1);
    localparam logic [SIG_W-1:0] TOP_BIT  = SIG_W'(1) << (SIG_W - 1);

    logic [SIG_W-1:0] bumped;
    logic             wrapped;

    assign bumped  = sig_i + HALF_ULP;
    assign wrapped = (bumped < sig_i);
    assign carry_o = (act_i == ACT_BUMP) && wrapped;

    always_comb begin
        sig_o  = sig_i;
        sexp_o = sexp_i;
        efld_o = efld_i;
        if (act_i == ACT_BUMP) begin
            if (wrapped) begin
                sig_o  = (bumped >> 1) | TOP_BIT;
                sexp_o = sexp_i + SEXP_W'(1);
                efld_o = efld_i + EFLD_W'(1);
            end else begin
                sig_o = bumped;
            end
        end
    end

endmodule

// File: rtl/rne_pack.sv
module rne_pack
    import rne_pkg::*;
#(
    parameter int SIG_W  = rne_pkg::SIG_W,
    parameter int RND_W  = rne_pkg::RND_W,
    parameter int SEXP_W = rne_pkg::SEXP_W,
    parameter int EFLD_W = rne_pkg::EFLD_W
) (
    input  logic                  sign_i,
    input  logic [SIG_W-1:0]      sig_i,
    input  logic [SEXP_W-1:0]     sexp_i,
    input  logic [EFLD_W-1:0]     efld_i,
    output logic [SIG_W-RND_W+EFLD_W-1:0] result_o,
    output logic                  inf_o
);
    localparam int MW = SIG_W - RND_W - 1;
    localparam logic [SEXP_W-1:0] SIGN_FLIP = SEXP_W'(1) << (SEXP_W - 1);
    localparam logic [SEXP_W-1:0] EXP_LIMIT = SEXP_W'(1) << (EFLD_W - 1);

    logic              below_limit;
    logic [EFLD_W-1:0] field_out;
    logic [MW-1:0]     mant_out;

    // signed compare done as unsigned after flipping the sign bits
    assign below_limit = (sexp_i ^ SIGN_FLIP) < (EXP_LIMIT ^ SIGN_FLIP);
    assign inf_o       = !below_limit;

    always_comb begin
        if (inf_o) begin
            field_out = '1;
            mant_out  = '0;
        end else begin
            mant_out = sig_i[SIG_W-2:RND_W];
            if ((efld_i == '0) && sig_i[SIG_W-1]) begin
                field_out = EFLD_W'(1);
            end else begin
                field_out = efld_i;
            end
        end
    end

    assign result_o = {sign_i, field_out, mant_out};

endmodule

// File: rtl/rne_pack_unit.sv
module rne_pack_unit
    import rne_pkg::*;
#(
    parameter int SIG_W  = rne_pkg::SIG_W,
    parameter int MANT_W = rne_pkg::MANT_W,
    parameter int EFLD_W = rne_pkg::EFLD_W,
    parameter int SEXP_W = rne_pkg::SEXP_W
) (
    input  logic                       sign_i,
    input  logic [SIG_W-1:0]           sig_i,
    input  logic [SEXP_W-1:0]          sexp_i,
    input  logic [EFLD_W-1:0]          efld_i,
    output logic [MANT_W+EFLD_W:0]     result_o
);
    localparam int RW = SIG_W - MANT_W - 1;

    rnd_zone_e         zone;
    rnd_act_e          act;
    logic [SIG_W-1:0]  sig_r;
    logic [SEXP_W-1:0] sexp_r;
    logic [EFLD_W-1:0] efld_r;
    logic              carry;
    logic              is_inf;

    rne_round_decide #(
        .SIG_W (SIG_W),
        .RND_W (RW)
    ) u_decide (
        .sig_i  (sig_i),
        .zone_o (zone),
        .act_o  (act)
    );

    rne_round_apply #(
        .SIG_W  (SIG_W),
        .RND_W  (RW),
        .SEXP_W (SEXP_W),
        .EFLD_W (EFLD_W)
    ) u_apply (
        .sig_i   (sig_i),
        .sexp_i  (sexp_i),
        .efld_i  (efld_i),
        .act_i   (act),
        .sig_o   (sig_r),
        .sexp_o  (sexp_r),
        .efld_o  (efld_r),
        .carry_o (carry)
    );

    rne_pack #(
        .SIG_W  (SIG_W),
        .RND_W  (RW),
        .SEXP_W (SEXP_W),
        .EFLD_W (EFLD_W)
    ) u_pack (
        .sign_i   (sign_i),
        .sig_i    (sig_r),
        .sexp_i   (sexp_r),
        .efld_i   (efld_r),
        .result_o (result_o),
        .inf_o    (is_inf)
    );

    always_comb begin
        if (zone == ZONE_TIE && !sig_i[RW] && !is_inf) begin
            AST_EVEN_TIE_KEEPS: assert (result_o[MANT_W-1:0] == sig_i[SIG_W-2:RW]); // R1
        end
        if (zone == ZONE_TIE && sig_i[RW]) begin
            AST_ODD_TIE_BUMPS: assert (act == ACT_BUMP); // R2
        end
        if (carry) begin
            AST_CARRY_RENORM: assert (sig_r[SIG_W-1:RW] == ({{(SIG_W-RW-1){1'b0}}, 1'b1} << (SIG_W-RW-1)) && sexp_r == sexp_i + SEXP_W'(1)); // R4
        end
        if (is_inf) begin
            AST_INF_ENCODING: assert (result_o[MANT_W+EFLD_W-1:MANT_W] == '1 && result_o[MANT_W-1:0] == '0 && result_o[MANT_W+EFLD_W] == sign_i); // R5
        end
        if (!is_inf && efld_r != '0) begin
            AST_FIELD_PASSES: assert (result_o[MANT_W+EFLD_W-1:MANT_W] == efld_r); // R7
        end
    end

endmodule

// File: tb/sim_rne_pack_unit.sv
module sim_rne_pack_unit;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic        s;
        logic [47:0] sig;
        logic [11:0] e;
        logic [7:0]  f;
        logic [31:0] want;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 48'h800000000000, 12'h000, 8'h7F, 32'h3F800000}, // R8 exact, no rounding
        '{1'b0, 48'hC000007FFFFF, 12'h000, 8'h7F, 32'h3FC00000}, // R3 just below half
        '{1'b0, 48'hC00000800001, 12'h000, 8'h7F, 32'h3FC00001}, // R3 just above half
        '{1'b0, 48'hC00000800000, 12'h000, 8'h7F, 32'h3FC00000}, // R1 tie, even kept
        '{1'b0, 48'hC00001800000, 12'h000, 8'h7F, 32'h3FC00002}, // R2 tie, odd bumped
        '{1'b1, 48'hC00001800000, 12'h000, 8'h7F, 32'hBFC00002}, // R2 R8 tie odd, negative
        '{1'b1, 48'hFFFFFF800000, 12'h000, 8'h7F, 32'hC0000000}, // R4 all-ones tie carry
        '{1'b0, 48'hFFFFFFFFFFFF, 12'h07F, 8'hFE, 32'h7F800000}, // R4 R5 carry to overflow
        '{1'b1, 48'h800000000000, 12'h080, 8'hFF, 32'hFF800000}, // R5 exponent at limit
        '{1'b0, 48'hFFFFFF000000, 12'h07F, 8'hFE, 32'h7F7FFFFF}, // R5 largest finite
        '{1'b0, 48'h800000000000, 12'h800, 8'h01, 32'h00800000}, // R6 most negative exponent
        '{1'b0, 48'h800000000000, 12'hFFF, 8'h7E, 32'h3F000000}, // R6 exponent -1
        '{1'b0, 48'h800000000000, 12'h7FF, 8'hFF, 32'h7F800000}, // R6 most positive exponent
        '{1'b0, 48'h000001000000, 12'hF82, 8'h00, 32'h00000001}, // R7 tiny subnormal
        '{1'b1, 48'h7FFFFF800000, 12'hF82, 8'h00, 32'h80800000}, // R7 subnormal promoted
        '{1'b0, 48'h7FFFFE800000, 12'hF82, 8'h00, 32'h007FFFFE}, // R7 R1 subnormal even tie
        '{1'b0, 48'h800000000001, 12'h000, 8'h7F, 32'h3F800000}  // R3 lone sticky bit
    };

    logic        clk = 1'b0;
    logic        sign_i = 1'b0;
    logic [47:0] sig_i = '0;
    logic [11:0] sexp_i = '0;
    logic [7:0]  efld_i = '0;
    logic [31:0] result_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rne_pack_unit u0 (
        .sign_i   (sign_i),
        .sig_i    (sig_i),
        .sexp_i   (sexp_i),
        .efld_i   (efld_i),
        .result_o (result_o)
    );

    task automatic apply_check(input logic s, input logic [47:0] sg, input logic [11:0] e,
                               input logic [7:0] f, input logic [31:0] want, input string req);
        @(negedge clk);
        sign_i = s;
        sig_i  = sg;
        sexp_i = e;
        efld_i = f;
        @(posedge clk);
        #1;
        total++;
        if (result_o !== want) begin
            bad++;
            $display("FAIL %s: sig=%h exp=%h fld=%h got=%h expected=%h",
                     req, sg, e, f, result_o, want);
        end
    endtask

    initial begin
        // initial state: all-zero inputs give +0 (R8 packing)
        @(posedge clk);
        #1;
        total++;
        if (result_o !== 32'h00000000) begin
            bad++;
            $display("FAIL R8 initial: got=%h expected=%h", result_o, 32'h00000000);
        end

        for (int i = 0; i < NV; i++) begin
            apply_check(VECS[i].s, VECS[i].sig, VECS[i].e, VECS[i].f, VECS[i].want, $sformatf("vec%0d", i));
        end

        // directed corners
        apply_check(1'b0, 48'hFFFFFE800000, 12'h07F, 8'hFE, 32'h7F7FFFFE, "R1 even tie at top exponent");
        apply_check(1'b0, 48'hFFFFFF800000, 12'h07E, 8'hFD, 32'h7F000000, "R4 carry lands below limit");
        apply_check(1'b1, 48'hFFFFFF7FFFFF, 12'h07F, 8'hFE, 32'hFF7FFFFF, "R3 near-carry truncated");
        apply_check(1'b0, 48'h7FFFFF7FFFFF, 12'hF82, 8'h00, 32'h007FFFFF, "R7 no promotion below half");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule